// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a table of small saturating counters organised as rows, one row per value of the low-order bits of the branch address. A shift register of the most recent resolved outcomes, taken or not taken and across all branches, picks one counter inside the selected row. Because of this, the same branch can get different predictions depending on what the branches just before it did.

The block has two sides. The lookup side takes a branch address and returns a taken/not-taken prediction at once. It also returns the history value in use, and the caller keeps that value with the branch. When the branch resolves, the update side receives the address, the real outcome and that kept history value. The update trains exactly the counter that made the prediction and shifts the outcome into the history register. An update that arrives late still trains the right counter, even if the history register has moved on since the lookup.

Top module: `hist_corr_predictor`

## Requirements
- R1: After reset every counter holds the weak not-taken value 2^(CTR_W-1)-1, so every lookup predicts not taken, and the history output is zero.
- R2: The prediction is the most significant bit of the counter at row `look_pc[ROW_BITS-1:0]`, column `look_hist`. A 1 means taken. The same address gives different predictions under different history values.
- R3: Each update shifts `upd_taken` (1 = taken) into bit 0 of the history register and drops the oldest bit. With no update, the history holds its value.
- R4: A taken update increments the selected counter and holds it at 2^CTR_W-1.
- R5: A not-taken update decrements the selected counter and holds it at 0. It never wraps.
- R6: An update changes only the counter at row `upd_pc[ROW_BITS-1:0]` and column `upd_hist`. The other counters in the same row keep their values, and the history register at update time plays no part.
- R7: Addresses with equal low ROW_BITS bits share a row, and no tag is compared.
- R8: With CTR_W=2, a counter saturated toward one direction needs two opposite outcomes in a row before its prediction flips.
- R9: When the lookup and the update select the same counter in the same cycle, the lookup returns the value from before that update.
- R10: With HIST_W=0, each row holds one counter, the history output stays 0, and the block acts as a plain per-address table of counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| look_pc | input | PC_W | Address of the branch being predicted |
| look_taken | output | 1 | Prediction, 1 = taken (combinational) |
| look_hist | output | max(HIST_W,1) | Current global history, to be kept with the branch |
| upd_valid | input | 1 | An outcome is being reported this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_hist | input | max(HIST_W,1) | History value returned at that branch's lookup |

## Verification
The bench builds two copies of the block: one with 16 rows, two history bits and 2-bit counters, and one with the same rows but no history. Sixteen rows are few enough that addresses such as 0x09 and 0x19 alias, and the reset state of every row can be checked. Two history bits let one address be trained to opposite predictions in separate columns. The copy without history shows the degenerate per-address table behaviour under the same stimulus. Each cycle of the stimulus table issues a lookup and an update to the same counter together, so every step also tests that the read comes before the write.

// File: rtl/hist_corr_predictor.sv
module hist_corr_predictor #(
  parameter int PC_W     = 32,
  parameter int ROW_BITS = 6,
  parameter int HIST_W   = 2,
  parameter int CTR_W    = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [PC_W-1:0]                        look_pc,
  output logic                                   look_taken,
  output logic [((HIST_W > 0) ? HIST_W : 1)-1:0] look_hist,
  input  logic                                   upd_valid,
  input  logic [PC_W-1:0]                        upd_pc,
  input  logic                                   upd_taken,
  input  logic [((HIST_W > 0) ? HIST_W : 1)-1:0] upd_hist
);
  localparam int HW    = (HIST_W > 0) ? HIST_W : 1;
  localparam int NCOL  = 1 << HIST_W;
  localparam int NENT  = (1 << ROW_BITS) * NCOL;
  localparam int IDX_W = ROW_BITS + HIST_W;
  localparam logic [CTR_W-1:0] CMAX    = '1;
  localparam logic [CTR_W-1:0] WEAK_NT = CTR_W'((1 << (CTR_W - 1)) - 1);
  localparam logic [HW-1:0]    HMASK   = HW'(NCOL - 1);

  logic [HW-1:0]    ghr;
  logic [CTR_W-1:0] ctr [NENT];

  function automatic logic [IDX_W-1:0] slot(input logic [ROW_BITS-1:0] row,
                                            input logic [HW-1:0] h);
    return IDX_W'(row) * IDX_W'(NCOL) + IDX_W'(h & HMASK);
  endfunction

  wire [IDX_W-1:0] look_idx = slot(look_pc[ROW_BITS-1:0], ghr);
  wire [IDX_W-1:0] upd_idx  = slot(upd_pc[ROW_BITS-1:0], upd_hist);
  wire [CTR_W-1:0] upd_cur  = ctr[upd_idx];
  wire unused_hi = ^{look_pc[PC_W-1:ROW_BITS], upd_pc[PC_W-1:ROW_BITS]};

  assign look_taken = ctr[look_idx][CTR_W-1];
  assign look_hist  = ghr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ghr <= '0;
      for (int i = 0; i < NENT; i++) ctr[i] <= WEAK_NT;
    end else if (upd_valid) begin
      ghr <= ((ghr << 1) | HW'(upd_taken)) & HMASK;
      if (upd_taken && upd_cur != CMAX)
        ctr[upd_idx] <= upd_cur + 1'b1;
      else if (!upd_taken && upd_cur != '0)
        ctr[upd_idx] <= upd_cur - 1'b1;
    end
  end
endmodule

// File: rtl/hist_corr_predictor_chk.sv
module hist_corr_predictor_chk #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 2
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic [PC_W-1:0]                        look_pc,
  input logic                                   look_taken,
  input logic [((HIST_W > 0) ? HIST_W : 1)-1:0] look_hist,
  input logic                                   upd_valid,
  input logic [PC_W-1:0]                        upd_pc,
  input logic                                   upd_taken
);
  a_r1_reset_hist: assert property (@(posedge clk)
    !rst_n |-> look_hist == '0);

  a_r3_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(look_hist));

  a_r3_hist_newest: assert property (@(posedge clk) disable iff (!rst_n)
    (HIST_W > 0 && upd_valid) |=> look_hist[0] == $past(upd_taken));

  a_r6_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid ##1 $stable(look_pc) |-> $stable(look_taken));

  a_r10_flat_hist: assert property (@(posedge clk) disable iff (!rst_n)
    HIST_W == 0 |-> look_hist == '0);

  a_r4_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    (HIST_W == 0 && upd_valid && upd_taken && upd_pc == look_pc && look_taken)
      ##1 $stable(look_pc) |-> look_taken);

  a_r5_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    (HIST_W == 0 && upd_valid && !upd_taken && upd_pc == look_pc && !look_taken)
      ##1 $stable(look_pc) |-> !look_taken);
endmodule

bind hist_corr_predictor hist_corr_predictor_chk #(.PC_W(PC_W), .HIST_W(HIST_W)) u_chk (.*);

// File: tb/hist_corr_predictor_test.sv
module hist_corr_predictor_test;
  localparam int PC_W = 16;
  localparam int RB   = 4;
  localparam int NV   = 20;
  localparam logic [16:0] VEC [NV] = '{
    17'h1_0004, 17'h1_0004, 17'h1_0008, 17'h0_0004, 17'h1_0014,
    17'h0_0008, 17'h1_0004, 17'h1_0004, 17'h0_00A3, 17'h1_0008,
    17'h1_0008, 17'h0_0014, 17'h1_00A3, 17'h1_0004, 17'h0_0004,
    17'h0_0004, 17'h1_0013, 17'h1_0003, 17'h0_0008, 17'h1_0004};

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] look_pc = '0, upd_pc = '0;
  logic upd_valid = 0, upd_taken = 0;
  logic [1:0] upd_hist = '0, look_hist;
  logic look_taken, fl_taken;
  logic [0:0] fl_hist;
  logic sp, sf;
  logic [1:0] sh;
  logic [0:0] sfh;
  int checks = 0, failures = 0;
  int m_ctr [64];
  int f_ctr [16];
  int m_ghr;
  bit done = 0;

  always #10 clk = ~clk;

  hist_corr_predictor #(.PC_W(PC_W), .ROW_BITS(RB), .HIST_W(2), .CTR_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .look_pc(look_pc), .look_taken(look_taken),
    .look_hist(look_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_hist(upd_hist));

  hist_corr_predictor #(.PC_W(PC_W), .ROW_BITS(RB), .HIST_W(0), .CTR_W(2)) uut_flat (
    .clk(clk), .rst_n(rst_n), .look_pc(look_pc), .look_taken(fl_taken),
    .look_hist(fl_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_hist(1'b0));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [PC_W-1:0] lpc, input bit uv,
                     input logic [PC_W-1:0] upc, input bit ut, input logic [1:0] uh);
    @(negedge clk);
    look_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_hist = uh;
    #1;
    sp = look_taken; sh = look_hist; sf = fl_taken; sfh = fl_hist;
    @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; upd_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  function automatic int bump(input int v, input bit t);
    if (t) return (v < 3) ? v + 1 : 3;
    return (v > 0) ? v - 1 : 0;
  endfunction

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: every row predicts not taken after reset, history zero
    for (int r = 0; r < 16; r++) begin
      cyc(PC_W'(r), 0, '0, 0, 2'd0);
      chk("R1 row pred", int'(sp), 0);
      chk("R1 flat row pred", int'(sf), 0);
    end
    chk("R1 hist", int'(sh), 0);

    // table walk: lookup and update hit the same counter each cycle (R2 R3 R9 R10)
    for (int i = 0; i < 64; i++) m_ctr[i] = 1;
    for (int i = 0; i < 16; i++) f_ctr[i] = 1;
    m_ghr = 0;
    for (int i = 0; i < NV; i++) begin
      automatic logic [PC_W-1:0] pc = VEC[i][15:0];
      automatic bit t = VEC[i][16];
      automatic int row = int'(pc[RB-1:0]);
      cyc(pc, 1, pc, t, 2'(m_ghr));
      chk("R2 table pred", int'(sp), int'(m_ctr[row*4 + m_ghr] >= 2));
      chk("R3 table hist", int'(sh), m_ghr);
      chk("R10 table flat pred", int'(sf), int'(f_ctr[row] >= 2));
      chk("R10 table flat hist", int'(sfh), 0);
      m_ctr[row*4 + m_ghr] = bump(m_ctr[row*4 + m_ghr], t);
      f_ctr[row] = bump(f_ctr[row], t);
      m_ghr = ((m_ghr << 1) | int'(t)) & 3;
    end

    // directed tests from a fresh reset
    do_reset();
    repeat (3) cyc(16'h0, 1, 16'h0009, 1, 2'd3);
    cyc(16'h0009, 0, '0, 0, 2'd0);
    chk("R4 saturated taken", int'(sp), 1);
    chk("R3 two taken give hist 3", int'(sh), 3);
    chk("R4 flat taken", int'(sf), 1);
    cyc(16'h0, 1, 16'h0009, 0, 2'd3);
    cyc(16'h0, 1, 16'h0005, 1, 2'd0);
    cyc(16'h0, 1, 16'h0005, 1, 2'd1);
    cyc(16'h0009, 0, '0, 0, 2'd0);
    chk("R8 one miss keeps taken", int'(sp), 1);
    chk("R8 flat one miss keeps taken", int'(sf), 1);
    cyc(16'h0, 1, 16'h0009, 0, 2'd3);
    cyc(16'h0, 1, 16'h0005, 1, 2'd2);
    cyc(16'h0, 1, 16'h0005, 1, 2'd1);
    cyc(16'h0009, 0, '0, 0, 2'd0);
    chk("R8 two misses flip", int'(sp), 0);
    chk("R8 flat two misses flip", int'(sf), 0);

    repeat (3) cyc(16'h0, 1, 16'h0009, 0, 2'd3);
    cyc(16'h0, 1, 16'h0009, 1, 2'd3);
    cyc(16'h0, 1, 16'h0005, 1, 2'd1);
    cyc(16'h0009, 0, '0, 0, 2'd0);
    chk("R5 no wrap below zero", int'(sp), 0);
    chk("R5 flat no wrap", int'(sf), 0);

    repeat (2) cyc(16'h0, 1, 16'h0009, 1, 2'd3);
    repeat (2) cyc(16'h0, 1, 16'h000C, 0, 2'd0);
    cyc(16'h0009, 0, '0, 0, 2'd0);
    chk("R6 neighbour column untouched", int'(sp), 0);
    chk("R3 hist after two not taken", int'(sh), 0);
    cyc(16'h0, 1, 16'h000C, 1, 2'd1);
    cyc(16'h0, 1, 16'h000C, 1, 2'd2);
    cyc(16'h0009, 0, '0, 0, 2'd0);
    chk("R2 same pc other history", int'(sp), 1);
    chk("R10 flat ignores history", int'(sf), 1);

    repeat (2) cyc(16'h0, 1, 16'h0019, 0, 2'd3);
    cyc(16'h0, 1, 16'h000C, 1, 2'd1);
    cyc(16'h0, 1, 16'h000C, 1, 2'd2);
    cyc(16'h0009, 0, '0, 0, 2'd0);
    chk("R7 alias trained row", int'(sp), 0);
    chk("R7 flat alias", int'(sf), 0);

    cyc(16'h0009, 1, 16'h0009, 1, 2'd3);
    chk("R9 read before write", int'(sp), 0);
    chk("R9 flat read before write", int'(sf), 0);
    cyc(16'h0009, 0, '0, 0, 2'd0);
    chk("R9 write visible next cycle", int'(sp), 1);
    chk("R9 flat write visible", int'(sf), 1);
    chk("R10 flat hist zero", int'(sfh), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule